// File: doc/BRIEF.md
# Byte-Serial Iterative SPN Encryption Core

This core encrypts one 64-bit block under an 80-bit key. The block is a substitution-permutation network with 25 rounds. All traffic uses byte-wide ports. A pulse on `go_i` while the core is idle opens a load window. For the first eight cycles of that window, one plaintext byte and one key byte enter together. Two further cycles carry the last two key bytes.

The datapath then completes one full round per clock. The round is a key XOR, a column-wise 4-bit S-box layer and a row-rotation permutation. The key schedule runs alongside the datapath and produces each new round key in the same clock as the round that consumes it. After the last round, a final round-key XOR forms the ciphertext. The ciphertext is then driven out one byte per cycle, most significant byte first, under a valid strobe.

The core then spends one warm-up cycle before it accepts the next request. The host needs no flow control. It only has to respect the fixed cycle counts given below.

Top module: `spn8_cipher`

## Requirements
- R1: While `rst_n` is low, and after its release until a request is accepted, `txt_vld_o` is 0 and `txt_o` is 0.
- R2: `go_i` is sampled only in the idle phase. Asserting it during loading, rounds, output or warm-up has no effect on the ciphertext or on the output timing. `txt_i` and `key_i` are ignored outside their load cycles.
- R3: Call the clock edge that samples `go_i` high in idle edge 0. Edges 1 to 8 sample plaintext bytes 7 down to 0, and with them key bytes 9 down to 2. Edges 9 and 10 sample key bytes 1 and 0. Byte n of a value occupies bits [8n+7:8n].
- R4: The state is four 16-bit rows, with row j at bits [16j+15:16j]. The S-box layer maps each column c through the table 0..F -> 6,5,C,A,1,E,7,9,B,0,3,D,8,F,4,2. The nibble of column c is {row3[c],row2[c],row1[c],row0[c]}, so row 0 is the least significant bit.
- R5: The permutation rotates rows 0, 1, 2 and 3 left by 0, 1, 12 and 13 bits.
- R6: The key is five 16-bit rows k0..k4, with k0 at bits [15:0]. Each update first applies the S-box to columns 0 to 3 of k0..k3. It then sets k0'=(k0<<<8)^k1, k1'=k2, k2'=k3, k3'=(k3<<<12)^k4 and k4'=k0. Finally it XORs a 5-bit constant into k0'[4:0]. The constant starts at 5'h01 for every block and steps as {rc[3:0], rc[4]^rc[2]}.
- R7: Each of the 25 rounds XORs the current key bits [63:0] into the state, then applies R4, then R5, then updates the key per R6. The ciphertext is the state after round 25 XORed with key bits [63:0] after the 25th update.
- R8: The ciphertext bytes appear after edges 35 to 42, most significant byte first. `txt_vld_o` is high in exactly those eight cycles.
- R9: In every cycle in which `txt_vld_o` is low, `txt_o` is 0.
- R10: Edge 43 enters a single warm-up cycle, which ignores `go_i`, and edge 44 enters idle. A new request can first be sampled at edge 45, and its result is independent of the previous block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Start request, sampled only in idle |
| txt_i | input | 8 | Plaintext byte during the load window |
| key_i | input | 8 | Key byte during the load window |
| txt_o | output | 8 | Ciphertext byte, 0 when not valid |
| txt_vld_o | output | 1 | Ciphertext byte valid strobe |

## Verification
Two events can fall on the same clock edge. The first is a start request. The second is a phase that must ignore it: a round, an output beat, or the warm-up edge that directly follows the last output byte. The bench provokes this on every other block of its sweep by holding `go_i` high from the first round edge through the warm-up edge, and by driving random bytes on both data inputs. Each such block is judged on two things: its ciphertext must match the reference, and its valid window must fall exactly on edges 35 to 42. The block that follows is then loaded normally, and a stray restart would shift its bytes, so its ciphertext would also fail to match.

// File: rtl/spn8_pkg.sv
package spn8_pkg;

    typedef enum logic [2:0] {
        PH_WARM  = 3'd0,
        PH_IDLE  = 3'd1,
        PH_FILL  = 3'd2,
        PH_KTAIL = 3'd3,
        PH_ROUND = 3'd4,
        PH_DRAIN = 3'd5
    } phase_e;

    // Left rotation applied to each data row by the permutation.
    localparam int DROT [4] = '{0, 1, 12, 13};

    // Rotations used by the key-schedule Feistel step.
    localparam int KROT_HEAD = 8;
    localparam int KROT_TAIL = 12;

    // Round constant generator.
    localparam int                RC_W    = 5;
    localparam logic [RC_W-1:0]   RC_SEED = 5'h01;

    function automatic logic [3:0] sbox4(input logic [3:0] x);
        logic [3:0] y;
        case (x)
            4'h0: y = 4'h6;
            4'h1: y = 4'h5;
            4'h2: y = 4'hC;
            4'h3: y = 4'hA;
            4'h4: y = 4'h1;
            4'h5: y = 4'hE;
            4'h6: y = 4'h7;
            4'h7: y = 4'h9;
            4'h8: y = 4'hB;
            4'h9: y = 4'h0;
            4'hA: y = 4'h3;
            4'hB: y = 4'hD;
            4'hC: y = 4'h8;
            4'hD: y = 4'hF;
            4'hE: y = 4'h4;
            default: y = 4'h2;
        endcase
        return y;
    endfunction

endpackage

// File: rtl/spn8_sbox_cols.sv
module spn8_sbox_cols
    import spn8_pkg::*;
#(
    parameter int ROW_W = 16,
    parameter int COLS  = 16
) (
    input  logic [4*ROW_W-1:0] rows_i,
    output logic [4*ROW_W-1:0] rows_o
);

    // A column takes one bit per row; row 0 is the nibble LSB.
    for (genvar c = 0; c < ROW_W; c++) begin : g_col
        if (c < COLS) begin : g_sub
            logic [3:0] nib_in;
            logic [3:0] nib_out;
            assign nib_in = {rows_i[3*ROW_W+c], rows_i[2*ROW_W+c],
                             rows_i[ROW_W+c],   rows_i[c]};
            assign nib_out = sbox4(nib_in);
            assign rows_o[c]         = nib_out[0];
            assign rows_o[ROW_W+c]   = nib_out[1];
            assign rows_o[2*ROW_W+c] = nib_out[2];
            assign rows_o[3*ROW_W+c] = nib_out[3];
        end else begin : g_pass
            assign rows_o[c]         = rows_i[c];
            assign rows_o[ROW_W+c]   = rows_i[ROW_W+c];
            assign rows_o[2*ROW_W+c] = rows_i[2*ROW_W+c];
            assign rows_o[3*ROW_W+c] = rows_i[3*ROW_W+c];
        end
    end

endmodule

// File: rtl/spn8_round.sv
module spn8_round
    import spn8_pkg::*;
#(
    parameter int ROW_W = 16
) (
    input  logic [4*ROW_W-1:0] st_i,
    input  logic [4*ROW_W-1:0] rk_i,
    output logic [4*ROW_W-1:0] st_o
);

    localparam int BLK_W = 4 * ROW_W;

    logic [BLK_W-1:0] keyed;
    logic [BLK_W-1:0] subst;

    assign keyed = st_i ^ rk_i;

    spn8_sbox_cols #(.ROW_W(ROW_W), .COLS(ROW_W)) u_sbox (
        .rows_i (keyed),
        .rows_o (subst)
    );

    // Row-wise left rotation, taken from a doubled copy of each row.
    for (genvar r = 0; r < 4; r++) begin : g_row
        logic [2*ROW_W-1:0] twin;
        assign twin = {subst[r*ROW_W +: ROW_W], subst[r*ROW_W +: ROW_W]};
        assign st_o[r*ROW_W +: ROW_W] = twin[2*ROW_W-1-DROT[r] -: ROW_W];
    end

endmodule

// File: rtl/spn8_keysched.sv
module spn8_keysched
    import spn8_pkg::*;
#(
    parameter int ROW_W   = 16,
    parameter int SB_COLS = 4
) (
    input  logic [5*ROW_W-1:0] key_i,
    input  logic [RC_W-1:0]    rc_i,
    output logic [5*ROW_W-1:0] key_o
);

    localparam int LOW_W = 4 * ROW_W;

    logic [LOW_W-1:0]   sub;
    logic [ROW_W-1:0]   r0, r1, r2, r3, r4;
    logic [2*ROW_W-1:0] r0_twin, r3_twin;
    logic [ROW_W-1:0]   head, tail, head_rc;

    spn8_sbox_cols #(.ROW_W(ROW_W), .COLS(SB_COLS)) u_sbox (
        .rows_i (key_i[LOW_W-1:0]),
        .rows_o (sub)
    );

    assign r0 = sub[0*ROW_W +: ROW_W];
    assign r1 = sub[1*ROW_W +: ROW_W];
    assign r2 = sub[2*ROW_W +: ROW_W];
    assign r3 = sub[3*ROW_W +: ROW_W];
    assign r4 = key_i[LOW_W +: ROW_W];

    assign r0_twin = {r0, r0};
    assign r3_twin = {r3, r3};
    assign head    = r0_twin[2*ROW_W-1-KROT_HEAD -: ROW_W] ^ r1;
    assign tail    = r3_twin[2*ROW_W-1-KROT_TAIL -: ROW_W] ^ r4;
    assign head_rc = head ^ {{(ROW_W-RC_W){1'b0}}, rc_i};

    assign key_o = {r0, tail, r3, r2, head_rc};

endmodule

// File: rtl/spn8_cipher.sv
module spn8_cipher
    import spn8_pkg::*;
#(
    parameter int ROW_W  = 16,
    parameter int PORT_W = 8,
    parameter int ROUNDS = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [PORT_W-1:0] txt_i,
    input  logic [PORT_W-1:0] key_i,
    output logic [PORT_W-1:0] txt_o,
    output logic              txt_vld_o
);

    localparam int BLK_W      = 4 * ROW_W;
    localparam int KEY_W      = 5 * ROW_W;
    localparam int DATA_BEATS = BLK_W / PORT_W;
    localparam int KEY_TAIL   = (KEY_W - BLK_W) / PORT_W;
    localparam int MAXC       = (ROUNDS > DATA_BEATS) ? ROUNDS : DATA_BEATS;
    localparam int CNT_W      = $clog2(MAXC);

    localparam logic [CNT_W-1:0] LAST_DATA  = CNT_W'(DATA_BEATS - 1);
    localparam logic [CNT_W-1:0] LAST_TAIL  = CNT_W'(KEY_TAIL - 1);
    localparam logic [CNT_W-1:0] LAST_ROUND = CNT_W'(ROUNDS - 1);

    typedef struct packed {
        phase_e             ph;
        logic [CNT_W-1:0]   cnt;
        logic [BLK_W-1:0]   st;
        logic [KEY_W-1:0]   key;
        logic [RC_W-1:0]    rc;
    } regs_t;

    regs_t q, d;

    logic [BLK_W-1:0] rnd_out;
    logic [KEY_W-1:0] key_nx;
    logic [RC_W-1:0]  rc_nx;

    spn8_round #(.ROW_W(ROW_W)) u_round (
        .st_i (q.st),
        .rk_i (q.key[BLK_W-1:0]),
        .st_o (rnd_out)
    );

    spn8_keysched #(.ROW_W(ROW_W), .SB_COLS(4)) u_ksched (
        .key_i (q.key),
        .rc_i  (q.rc),
        .key_o (key_nx)
    );

    assign rc_nx = {q.rc[RC_W-2:0], q.rc[RC_W-1] ^ q.rc[2]};

    always_comb begin
        d = q;
        case (q.ph)
            PH_WARM: begin
                d.ph  = PH_IDLE;
                d.cnt = '0;
            end
            PH_IDLE: begin
                d.cnt = '0;
                if (go_i) d.ph = PH_FILL;
            end
            PH_FILL: begin
                d.st  = {q.st[BLK_W-PORT_W-1:0], txt_i};
                d.key = {q.key[KEY_W-PORT_W-1:0], key_i};
                if (q.cnt == LAST_DATA) begin
                    d.ph  = PH_KTAIL;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            PH_KTAIL: begin
                d.key = {q.key[KEY_W-PORT_W-1:0], key_i};
                if (q.cnt == LAST_TAIL) begin
                    d.ph  = PH_ROUND;
                    d.cnt = '0;
                    d.rc  = RC_SEED;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            PH_ROUND: begin
                d.key = key_nx;
                d.rc  = rc_nx;
                if (q.cnt == LAST_ROUND) begin
                    d.st  = rnd_out ^ key_nx[BLK_W-1:0];
                    d.ph  = PH_DRAIN;
                    d.cnt = '0;
                end else begin
                    d.st  = rnd_out;
                    d.cnt = q.cnt + 1'b1;
                end
            end
            PH_DRAIN: begin
                d.st = {q.st[BLK_W-PORT_W-1:0], {PORT_W{1'b0}}};
                if (q.cnt == LAST_DATA) begin
                    d.ph  = PH_WARM;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: begin
                d.ph  = PH_WARM;
                d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign txt_vld_o = (q.ph == PH_DRAIN);
    assign txt_o     = txt_vld_o ? q.st[BLK_W-1 -: PORT_W] : '0;

endmodule

// File: rtl/spn8_cipher_chk.sv
module spn8_cipher_chk
    import spn8_pkg::*;
#(
    parameter int ROW_W  = 16,
    parameter int PORT_W = 8,
    parameter int ROUNDS = 25
) (
    input logic                                   clk,
    input logic                                   rst_n,
    input logic                                   go_i,
    input logic                                   vld_i,
    input logic [PORT_W-1:0]                      byte_i,
    input phase_e                                 ph_i,
    input logic [$clog2((ROUNDS > (4*ROW_W)/PORT_W) ? ROUNDS : (4*ROW_W)/PORT_W)-1:0] cnt_i
);

    localparam int MAXC = (ROUNDS > (4*ROW_W)/PORT_W) ? ROUNDS : (4*ROW_W)/PORT_W;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_i == PH_IDLE && !go_i) |=> (ph_i == PH_IDLE)); // R2

    AST_FILL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_i == PH_FILL && $past(ph_i) != PH_FILL) |-> ($past(ph_i) == PH_IDLE && $past(go_i))); // R2

    AST_WARM_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_i == PH_WARM) |=> (ph_i == PH_IDLE)); // R10

    AST_VLD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vld_i) |-> ($past(ph_i) == PH_ROUND)); // R8

    AST_VLD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vld_i) |-> (ph_i == PH_WARM)); // R10

    AST_QUIET_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |-> (byte_i == '0)); // R9

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cnt_i) < MAXC)); // R8

endmodule

bind spn8_cipher spn8_cipher_chk #(
    .ROW_W  (ROW_W),
    .PORT_W (PORT_W),
    .ROUNDS (ROUNDS)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (go_i),
    .vld_i  (txt_vld_o),
    .byte_i (txt_o),
    .ph_i   (q.ph),
    .cnt_i  (q.cnt)
);

// File: tb/spn8_cipher_test.sv
module spn8_cipher_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       go_i = 1'b0;
    logic [7:0] txt_i = '0;
    logic [7:0] key_i = '0;
    logic [7:0] txt_o;
    logic       txt_vld_o;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    spn8_cipher uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_i      (go_i),
        .txt_i     (txt_i),
        .key_i     (key_i),
        .txt_o     (txt_o),
        .txt_vld_o (txt_vld_o)
    );

    localparam logic [3:0] SB [16] = '{4'h6, 4'h5, 4'hC, 4'hA, 4'h1, 4'hE, 4'h7, 4'h9,
                                       4'hB, 4'h0, 4'h3, 4'hD, 4'h8, 4'hF, 4'h4, 4'h2};
    localparam int ROT [4] = '{0, 1, 12, 13};

    function automatic logic [15:0] rotl16(input logic [15:0] x, input int n);
        logic [15:0] y;
        for (int i = 0; i < 16; i++) y[(i + n) % 16] = x[i];
        return y;
    endfunction

    function automatic logic [63:0] ref_enc(input logic [63:0] p, input logic [79:0] k);
        logic [15:0] kr [5];
        logic [15:0] nk [5];
        logic [63:0] s, t;
        logic [4:0]  rc;
        logic [3:0]  nb;
        s  = p;
        rc = 5'h01;
        for (int j = 0; j < 5; j++) kr[j] = k[16*j +: 16];
        for (int r = 0; r < 25; r++) begin
            s = s ^ {kr[3], kr[2], kr[1], kr[0]};
            for (int c = 0; c < 16; c++) begin
                nb = SB[{s[48+c], s[32+c], s[16+c], s[c]}];
                s[c] = nb[0]; s[16+c] = nb[1]; s[32+c] = nb[2]; s[48+c] = nb[3];
            end
            t = s;
            for (int w = 0; w < 4; w++)
                for (int i = 0; i < 16; i++)
                    s[16*w + ((i + ROT[w]) % 16)] = t[16*w + i];
            for (int c = 0; c < 4; c++) begin
                nb = SB[{kr[3][c], kr[2][c], kr[1][c], kr[0][c]}];
                kr[0][c] = nb[0]; kr[1][c] = nb[1]; kr[2][c] = nb[2]; kr[3][c] = nb[3];
            end
            nk[0] = rotl16(kr[0], 8) ^ kr[1];
            nk[1] = kr[2];
            nk[2] = kr[3];
            nk[3] = rotl16(kr[3], 12) ^ kr[4];
            nk[4] = kr[0];
            nk[0][4:0] = nk[0][4:0] ^ rc;
            for (int j = 0; j < 5; j++) kr[j] = nk[j];
            rc = {rc[3:0], rc[4] ^ rc[2]};
        end
        return s ^ {kr[3], kr[2], kr[1], kr[0]};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Runs one block; noisy blocks hold go_i high and drive junk while it must be ignored.
    task automatic run_block(input logic [63:0] pt, input logic [79:0] key, input bit noisy);
        logic [63:0] exp_ct, got;
        int          bad_vld, bad_quiet, bad_tail;
        exp_ct = ref_enc(pt, key);
        got = '0; bad_vld = 0; bad_quiet = 0; bad_tail = 0;
        @(negedge clk);
        go_i = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            go_i  = 1'b0;
            txt_i = (i < 8) ? pt[63 - 8*i -: 8] : 8'($urandom);
            key_i = key[79 - 8*i -: 8];
        end
        for (int n = 10; n <= 45; n++) begin
            @(negedge clk);
            if (n >= 35 && n <= 42) begin
                if (!txt_vld_o) bad_vld++;
                got[63 - 8*(n-35) -: 8] = txt_o;
            end else begin
                if (txt_vld_o) begin
                    if (n >= 43) bad_tail++;
                    else         bad_vld++;
                end
                if (txt_o != 8'h00) bad_quiet++;
            end
            txt_i = 8'($urandom);
            key_i = 8'($urandom);
            go_i  = (noisy && n <= 43) ? 1'b1 : 1'b0;
        end
        check(bad_vld == 0, "R8", "valid window after edges 35..42", 80'(bad_vld), 80'd0);
        check(bad_quiet == 0, "R9", "output zero while not valid", 80'(bad_quiet), 80'd0);
        check(bad_tail == 0, "R10", "valid low through warm-up and idle", 80'(bad_tail), 80'd0);
        if (noisy)
            check(got == exp_ct, "R2", "ciphertext with go and data noise", 80'(got), 80'(exp_ct));
        else
            check(got == exp_ct, "R3 R4 R5 R6 R7", "ciphertext", 80'(got), 80'(exp_ct));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [63:0] lcg;
        int          blk;
        lcg = 64'h0123_4567_89AB_CDEF;
        blk = 0;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(txt_vld_o == 1'b0 && txt_o == 8'h00, "R1", "outputs during reset",
              80'({txt_vld_o, txt_o}), 80'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(txt_vld_o == 1'b0 && txt_o == 8'h00, "R1", "outputs idle after reset",
              80'({txt_vld_o, txt_o}), 80'd0);

        run_block(64'h0, 80'h0, 1'b0);
        run_block('1, '1, 1'b0);
        run_block(64'h0, 80'h0, 1'b1);       // R10: repeat must equal the first block
        // Walking plaintext bit sweep, R4 and R5 exercised per column and row
        for (int b = 0; b < 64; b++) begin
            run_block(64'h1 << b, 80'h0, blk[0]);
            blk++;
        end
        // Walking key bit sweep, R3 and R6 exercised per key row
        for (int b = 0; b < 80; b++) begin
            run_block(64'h0, 80'h1 << b, blk[0]);
            blk++;
        end
        for (int b = 0; b < 24; b++) begin
            logic [63:0] p;
            logic [79:0] k;
            lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
            p   = lcg;
            lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
            k   = {lcg[15:0], p ^ lcg};
            run_block(p, k, blk[0]);
            blk++;
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule